// File: doc/BRIEF.md
# Split-Array Frame Readout Sequencer

This block scans a pixel array whose latched conversion words are read out as two halves in lock-step. The upper and the lower half each have ROWS row lines and COLS columns. When a frame is requested, the sequencer first issues a one-cycle transfer strobe, which makes the array copy its live results into the in-pixel hold latches. The array can then start acquiring the next frame while the held one is read out.

After the transfer the sequencer enables one row in each half. That row drives all of its column buses at once. A per-half column multiplexer then moves across the columns and sends one word per clock to the output of its half. The two halves share the row and column counters, so both outputs carry words with the same local indices in the same cycle. The row number in the lower half is local: its physical row is ROWS plus the reported index.

With the default 16 rows by 32 columns, a frame takes 512 words on each output, plus one transfer cycle and one pipeline cycle. At 50 MHz this is roughly 10 µs per frame. A request that arrives during a frame is remembered and starts the next frame as soon as the current scan has issued its last word.

Top module: `frame_readout_seq`

## Requirements
- R1: After reset, pix_latch, row_en, busy and word_valid are all low.
- R2: A frame_start sampled while the sequencer is idle makes pix_latch high for exactly one cycle, starting in the cycle after the sampling edge. busy is high in that same cycle.
- R3: row_en rises in the cycle after the pix_latch cycle and stays high for exactly ROWS*COLS consecutive cycles. row_sel starts at 0 in the first of these cycles.
- R4: Each frame delivers ROWS*COLS words with word_valid high on consecutive clocks, with no gaps. The order is row-major: word_row goes from 0 to ROWS-1, and within each row word_col goes from 0 to COLS-1.
- R5: In the same cycle, upper_word carries the upper-half bus word of the indicated column, and lower_word carries the lower-half bus word of that column. The bus words are those driven while row_sel equalled the indicated row. Word c of a bus occupies bits [c*W +: W], and both halves belong to the frame captured by the latest pix_latch.
- R6: For an isolated frame, busy stays high for exactly ROWS*COLS+2 consecutive cycles: the transfer cycle, the scan, and the cycle of the last word. After that it falls.
- R7: A frame_start sampled while busy is not lost. The next pix_latch comes in the cycle after the last word of the running frame, so busy stays high without a break across both frames.
- R8: Any number of frame_start pulses sampled during one busy frame queue exactly one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to transfer and read one frame |
| upper_bus | input | COLS*W | Column buses of the upper half, word c at [c*W +: W] |
| lower_bus | input | COLS*W | Column buses of the lower half, word c at [c*W +: W] |
| pix_latch | output | 1 | One-cycle strobe that copies live pixel results into the hold latches |
| row_en | output | 1 | Row drive enable for both halves |
| row_sel | output | $clog2(ROWS) | Selected row within each half |
| busy | output | 1 | High from the transfer cycle until the last word has been sent |
| word_valid | output | 1 | Output words and indices are valid |
| word_row | output | $clog2(ROWS) | Local row of the current words |
| word_col | output | $clog2(COLS) | Column of the current words |
| upper_word | output | W | Current upper-half word |
| lower_word | output | W | Current lower-half word |

## Verification
The bench builds the block at its default 16 by 32 by 16-bit size. Every word position of the full frame is therefore compared on both halves in each frame. The array model gives every word a code made of the frame number, the half, the row and the column. This makes any misordering, half swap or stale-frame read show up as a wrong code at a known index.

Requests are placed in three positions: an isolated request, a request queued during a scan, and several requests during one scan. These bring into reach the exact busy length, the back-to-back handover and the collapsing of queued requests.

// File: rtl/frame_readout_pkg.sv
package frame_readout_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_SCAN  = 2'd2
  } phase_t;

endpackage

// File: rtl/frame_scan_ctrl.sv
module frame_scan_ctrl
  import frame_readout_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start_i,
  output logic          latch_o,
  output logic          scan_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          busy_o,
  output logic          vld_o,
  output logic [RW-1:0] vrow_o,
  output logic [CW-1:0] vcol_o
);

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  phase_t        ph_q;
  logic          pend_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          vld_q;
  logic [RW-1:0] vrow_q;
  logic [CW-1:0] vcol_q;
  logic          accept;

  assign accept = (ph_q == PH_IDLE) && (frame_start_i || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      pend_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      vrow_q <= '0;
      vcol_q <= '0;
    end else begin
      pend_q <= accept ? 1'b0 : (pend_q | frame_start_i);
      vld_q  <= (ph_q == PH_SCAN);
      vrow_q <= row_q;
      vcol_q <= col_q;
      case (ph_q)
        PH_IDLE: if (accept) ph_q <= PH_LATCH;
        PH_LATCH: begin
          ph_q  <= PH_SCAN;
          row_q <= '0;
          col_q <= '0;
        end
        PH_SCAN: begin
          if (col_q == COL_LAST) begin
            col_q <= '0;
            if (row_q == ROW_LAST) ph_q <= PH_IDLE;
            else row_q <= row_q + RW'(1);
          end else begin
            col_q <= col_q + CW'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign latch_o = (ph_q == PH_LATCH);
  assign scan_o  = (ph_q == PH_SCAN);
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign busy_o  = (ph_q != PH_IDLE) || vld_q;
  assign vld_o   = vld_q;
  assign vrow_o  = vrow_q;
  assign vcol_o  = vcol_q;

  // R2: transfer strobe lasts a single cycle
  p_latch_single_r2: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> !latch_o);

  // R3: scan begins right after the transfer strobe, at row 0 column 0
  p_scan_after_latch_r3: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> (scan_o && row_o == '0 && col_o == '0));

  // R4: column steps by one within a row
  p_col_step_r4: assert property (@(posedge clk) disable iff (rst)
    (scan_o && col_o != COL_LAST) |=> (col_o == $past(col_o) + CW'(1) && $stable(row_o)));

  // R4: row advances on column wrap
  p_row_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (scan_o && col_o == COL_LAST && row_o != ROW_LAST) |=> (scan_o && col_o == '0 && row_o == $past(row_o) + RW'(1)));

  // R4: every scan cycle yields a valid word next cycle
  p_word_follows_scan_r4: assert property (@(posedge clk) disable iff (rst)
    scan_o |=> vld_o);

  // R7: no new transfer strobe while the scan is running
  p_no_latch_in_scan_r7: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> !$past(scan_o && !(row_o == ROW_LAST && col_o == COL_LAST)));

endmodule

// File: rtl/half_col_mux.sv
module half_col_mux #(
  parameter int COLS = 32,
  parameter int W    = 16,
  localparam int CW  = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_i,
  input  logic [CW-1:0]   col_i,
  input  logic [COLS*W-1:0] bus_i,
  output logic [W-1:0]    word_o
);

  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (scan_i) word_q <= bus_i[col_i*W +: W];
  end

  assign word_o = word_q;

  // R5: output word changes only on a scan cycle
  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !scan_i |=> $stable(word_o));

endmodule

// File: rtl/frame_readout_seq.sv
module frame_readout_seq #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  parameter int W    = 16,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [COLS*W-1:0] upper_bus,
  input  logic [COLS*W-1:0] lower_bus,
  output logic              pix_latch,
  output logic              row_en,
  output logic [RW-1:0]     row_sel,
  output logic              busy,
  output logic              word_valid,
  output logic [RW-1:0]     word_row,
  output logic [CW-1:0]     word_col,
  output logic [W-1:0]      upper_word,
  output logic [W-1:0]      lower_word
);

  localparam int HALVES = 2;

  logic              scan;
  logic [CW-1:0]     col;
  logic [COLS*W-1:0] bus_arr  [HALVES];
  logic [W-1:0]      word_arr [HALVES];

  frame_scan_ctrl #(.ROWS(ROWS), .COLS(COLS)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .frame_start_i(frame_start),
    .latch_o      (pix_latch),
    .scan_o       (scan),
    .row_o        (row_sel),
    .col_o        (col),
    .busy_o       (busy),
    .vld_o        (word_valid),
    .vrow_o       (word_row),
    .vcol_o       (word_col)
  );

  assign row_en     = scan;
  assign bus_arr[0] = upper_bus;
  assign bus_arr[1] = lower_bus;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    half_col_mux #(.COLS(COLS), .W(W)) i_mux (
      .clk   (clk),
      .rst   (rst),
      .scan_i(scan),
      .col_i (col),
      .bus_i (bus_arr[h]),
      .word_o(word_arr[h])
    );
  end

  assign upper_word = word_arr[0];
  assign lower_word = word_arr[1];

  // R1: nothing is active in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!pix_latch && !row_en && !busy && !word_valid));

  // R6: busy covers row drive and valid words
  p_busy_covers_r6: assert property (@(posedge clk) disable iff (rst)
    (row_en || word_valid || pix_latch) |-> busy);

endmodule

// File: tb/test_frame_readout_seq.sv
`timescale 1ns/1ps
module test_frame_readout_seq;

  localparam int R  = 16;
  localparam int C  = 32;
  localparam int W  = 16;
  localparam int N  = R * C;
  localparam int RW = $clog2(R);
  localparam int CW = $clog2(C);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [C*W-1:0] upper_bus, lower_bus;
  logic pix_latch, row_en, busy, word_valid;
  logic [RW-1:0] row_sel, word_row;
  logic [CW-1:0] word_col;
  logic [W-1:0] upper_word, lower_word;

  always #4 clk = ~clk;

  frame_readout_seq #(.ROWS(R), .COLS(C), .W(W)) i_frame_readout_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .upper_bus(upper_bus), .lower_bus(lower_bus),
    .pix_latch(pix_latch), .row_en(row_en), .row_sel(row_sel),
    .busy(busy), .word_valid(word_valid), .word_row(word_row),
    .word_col(word_col), .upper_word(upper_word), .lower_word(lower_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int id, input bit h, input int r, input int c);
    return {4'(id), h, 5'(r), 6'(c)};
  endfunction

  // array model: hold latches take a new frame number at each transfer strobe
  int shot_id = -1;
  always @(posedge clk) if (pix_latch) shot_id <= shot_id + 1;

  for (genvar c = 0; c < C; c++) begin : g_bus
    assign upper_bus[c*W +: W] = pat(shot_id, 1'b0, int'(row_sel), c);
    assign lower_bus[c*W +: W] = pat(shot_id, 1'b1, int'(row_sel), c);
  end

  // word monitor: R4 order and continuity, R5 data
  int widx = 0;
  int fr_cnt = 0;
  bit mon_err = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        if (!mon_err) begin
          chk(int'(word_row) == widx / C, "R4 word_row", word_row, widx / C);
          chk(int'(word_col) == widx % C, "R4 word_col", word_col, widx % C);
          chk(upper_word == pat(fr_cnt, 1'b0, widx / C, widx % C), "R5 upper_word",
              upper_word, pat(fr_cnt, 1'b0, widx / C, widx % C));
          chk(lower_word == pat(fr_cnt, 1'b1, widx / C, widx % C), "R5 lower_word",
              lower_word, pat(fr_cnt, 1'b1, widx / C, widx % C));
          if (fails > 0) mon_err = 1'b1;
        end
        if (widx == N - 1) begin widx = 0; fr_cnt++; end
        else widx++;
      end else if (widx != 0) begin
        chk(1'b0, "R4 gap inside frame", widx, 0);
        widx = 0;
      end
    end
  end

  int busy_len, latch_cnt, rowen_cnt, first_row;

  // from the negedge after frame_start was sampled, count until busy falls
  task automatic run_frames(input int q1, input int q2, input int q3);
    busy_len = 0; latch_cnt = 0; rowen_cnt = 0; first_row = -1;
    while (busy && busy_len < 4 * N) begin
      busy_len++;
      if (pix_latch) latch_cnt++;
      if (row_en) begin
        if (rowen_cnt == 0) first_row = int'(row_sel);
        rowen_cnt++;
      end
      frame_start = (busy_len == q1) || (busy_len == q2) || (busy_len == q3);
      @(negedge clk);
    end
    frame_start = 1'b0;
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!pix_latch, "R1 pix_latch", pix_latch, 0);
    chk(!row_en, "R1 row_en", row_en, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(!word_valid, "R1 word_valid", word_valid, 0);

    // isolated frame
    pulse_start();
    chk(pix_latch, "R2 pix_latch high", pix_latch, 1);
    chk(busy, "R2 busy with latch", busy, 1);
    run_frames(0, 0, 0);
    chk(latch_cnt == 1, "R2 one latch pulse", latch_cnt, 1);
    chk(rowen_cnt == N, "R3 row_en length", rowen_cnt, N);
    chk(first_row == 0, "R3 first row_sel", first_row, 0);
    chk(busy_len == N + 2, "R6 busy length", busy_len, N + 2);
    chk(fr_cnt == 1, "R4 frames completed", fr_cnt, 1);

    // idle: nothing starts on its own
    repeat (20) @(negedge clk);
    chk(!busy && !word_valid && !row_en, "R1 idle stays quiet", busy, 0);

    // queued request near the middle of a frame
    pulse_start();
    run_frames(200, 0, 0);
    chk(latch_cnt == 2, "R7 queued latch count", latch_cnt, 2);
    chk(busy_len == 2 * (N + 2), "R7 busy unbroken", busy_len, 2 * (N + 2));
    chk(rowen_cnt == 2 * N, "R3 row_en two frames", rowen_cnt, 2 * N);
    chk(fr_cnt == 3, "R7 frames completed", fr_cnt, 3);

    // several requests in one frame, including the transfer and the last-word cycle
    pulse_start();
    run_frames(1, 300, N + 1);
    chk(latch_cnt == 2, "R8 collapsed latch count", latch_cnt, 2);
    chk(busy_len == 2 * (N + 2), "R8 busy length", busy_len, 2 * (N + 2));
    chk(fr_cnt == 5, "R8 frames completed", fr_cnt, 5);

    repeat (5) @(negedge clk);
    chk(!busy, "R6 busy low at end", busy, 0);
    chk(widx == 0, "R4 no partial frame", widx, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule